// File: doc/BRIEF.md
# Reset Cause Recorder and Sequencer

This block sits beside a processor core and decides when the core is put into reset, and why. Four asynchronous, active-low request lines feed it: a manual push button, a power-fail comparator, a watchdog timeout and an illegal-fetch strobe. A small register bus adds two software requests. The lines are synchronised and merged into one request level. The first fall of that level in a reset cycle is decoded into exactly one cause. The cause is latched as a sticky flag, and after a fixed delay a stretched reset pulse is driven to the core.

The flag register is cleared only by the cold power-on reset of the block itself. The core resets that the block produces leave it alone, so firmware can read the flags after each restart and choose how to recover. A value of all zeros means the last restart came from power-on. Software clears individual flags by writing ones. An undervoltage cause can optionally park the core in a low-power hold instead of resetting it at once, and release the reset only after the power-fail line has recovered.

Top module: `rst_cause_seq`

## Requirements
- R1: `cause_flags` holds the flags at fixed positions: bit5 manual, bit4 undervoltage, bit3 watchdog, bit2 illegal fetch, bit1 hardware-plus-software request, bit0 software request. Bits 7 and 6 always read zero, and after cold reset the whole byte is zero.
- R2: When a request event is decoded, exactly one hardware flag is set, by priority: manual line low beats power-fail low, and power-fail low beats watchdog low.
- R3: An event during which the manual, power-fail and watchdog lines are all high sets the illegal-fetch flag (bit2).
- R4: A request line that falls just before rising edge 1 makes its flag visible after rising edge 3, and not before. This is two synchroniser stages plus the flag register.
- R5: A bus write with `bus_addr`=1 and data bit1 set sets bit1 and starts a reset sequence if none is running. Data bit0 set sets bit0 and never asserts `core_rst`. Data bits 7:2 at this address have no effect.
- R6: `core_rst` rises exactly `DLY_CYC` rising edges after the edge on which the sequence starts.
- R7: `core_rst` stays high for at least `PULSE_LEN` cycles, even for a one-cycle request. It is held longer while any synchronised request line is still low, and falls on the first edge at which the count is spent and every synchronised line is high.
- R8: Flags are sticky. They survive the `core_rst` pulses the block generates and accumulate across events, and only `cold_rst` returns them to zero.
- R9: From the start of a sequence until `core_rst` falls, further request-line falls set no flag and start no new sequence.
- R10: A bus write with `bus_addr`=0 clears every flag whose data bit is one. A flag being set on the same edge stays set.
- R11: `power_on` is high exactly when all six flags are zero.
- R12: With `HOLD_ON_PFAIL`=1, an undervoltage cause raises `hold_lp` and withholds `core_rst`. Three edges after the power-fail line returns high, `hold_lp` falls and the normal delay and pulse follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| cold_rst | input | 1 | Synchronous active-high power-on reset; clears everything |
| man_req_n | input | 1 | Manual reset button, active low, asynchronous |
| pfail_n | input | 1 | Power-fail comparator, active low, asynchronous |
| wdog_n | input | 1 | Watchdog timeout, active low, asynchronous |
| fetch_err_n | input | 1 | Illegal-fetch strobe, active low, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0: flag clear register, 1: software request register |
| bus_wdata | input | 8 | Write data |
| cause_flags | output | 8 | Sticky cause flags (read value) |
| power_on | output | 1 | High when no flag is set |
| core_rst | output | 1 | Active-high reset to the core |
| hold_lp | output | 1 | Low-power hold during an undervoltage event |

## Verification
The bench builds the block with `DLY_CYC`=3, `PULSE_LEN`=16, `HOLD_ON_PFAIL`=1 and two synchroniser stages. The short delay keeps the cycle-exact checks of the rise, the fall and the stretched pulse cheap. The pulse length is left at its floor so that a one-cycle strobe exercises the minimum-width rule. With the hold variant enabled, every power-fail cause goes through the hold-then-release path. Random masks of simultaneous low lines, mixed with random clear writes and software requests, sweep the priority decode against a bench model of the flag byte.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int CAUSE_W = 8;
  localparam int FLAG_W  = 6;

  // Flag positions in the cause byte
  localparam int B_MAN = 5;
  localparam int B_UV  = 4;
  localparam int B_WD  = 3;
  localparam int B_IA  = 2;
  localparam int B_HS  = 1;
  localparam int B_SW  = 0;

  // Request line order on the merged vector
  localparam int N_REQ = 4;
  localparam int L_MAN = 0;
  localparam int L_PF  = 1;
  localparam int L_WD  = 2;
  localparam int L_IF  = 3;

  // One-hot hardware cause, index 3..0 maps to flags 5..2
  localparam int HW_W = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_HOLD  = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_PULSE = 2'd3
  } seq_state_t;

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  // Idle level of active-low lines is high
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/rcs_decode.sv
module rcs_decode
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] lines_n,
  input  logic             armed,
  output logic             fire,
  output logic [HW_W-1:0]  cause_oh,
  output logic             any_req
);

  logic merged_n;
  logic prev_n_q;

  assign merged_n = &lines_n;
  assign any_req  = ~merged_n;

  always_ff @(posedge clk) begin
    if (rst) prev_n_q <= 1'b1;
    else     prev_n_q <= merged_n;
  end

  // Falling edge of the merged level, only while the sequencer is idle
  assign fire = armed & prev_n_q & ~merged_n;

  // Priority: manual, then power-fail, then watchdog, else illegal fetch
  always_comb begin
    cause_oh = '0;
    if (!lines_n[L_MAN])     cause_oh[3] = 1'b1;
    else if (!lines_n[L_PF]) cause_oh[2] = 1'b1;
    else if (!lines_n[L_WD]) cause_oh[1] = 1'b1;
    else                     cause_oh[0] = 1'b1;
  end

  // R2: a decoded event names exactly one hardware cause
  p_onehot_cause_r2: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($countones(cause_oh) == 1));

endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
  import rcs_pkg::*;
#(
  parameter int DLY_CYC       = 4,
  parameter int PULSE_LEN     = 16,
  parameter int HOLD_ON_PFAIL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_hold,
  input  logic pf_ok,
  input  logic req_active,
  output logic core_rst,
  output logic hold_lp,
  output logic busy
);

  localparam int  MAXC    = (DLY_CYC > PULSE_LEN) ? DLY_CYC : PULSE_LEN;
  localparam int  CNT_W   = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LD = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] PUL_LD = CNT_W'(PULSE_LEN - 1);
  localparam bit  HOLD_EN = (HOLD_ON_PFAIL != 0);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      core_rst <= 1'b0;
      hold_lp  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            if (start_hold && HOLD_EN) begin
              state_q <= SQ_HOLD;
              hold_lp <= 1'b1;
            end else begin
              state_q <= SQ_WAIT;
              cnt_q   <= DLY_LD;
            end
          end
        end
        SQ_HOLD: begin
          if (pf_ok) begin
            state_q <= SQ_WAIT;
            cnt_q   <= DLY_LD;
            hold_lp <= 1'b0;
          end
        end
        SQ_WAIT: begin
          if (cnt_q == '0) begin
            state_q  <= SQ_PULSE;
            cnt_q    <= PUL_LD;
            core_rst <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_PULSE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!req_active) begin
            state_q  <= SQ_IDLE;
            core_rst <= 1'b0;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q != SQ_IDLE);

  // Checker: width of the current high phase of core_rst, saturating
  localparam int HI_W = $clog2(PULSE_LEN + 1);
  logic [HI_W-1:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                                   hi_cnt_q <= '0;
    else if (!core_rst)                        hi_cnt_q <= '0;
    else if (hi_cnt_q < HI_W'(PULSE_LEN))      hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // R7: pulse never shorter than PULSE_LEN cycles
  p_min_width_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (hi_cnt_q >= HI_W'(PULSE_LEN)));

  // R6: reset only rises out of the delay phase
  p_rise_after_wait_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> ($past(state_q) == SQ_WAIT));

  // R12: hold and reset are never active together
  p_hold_no_rst_r12: assert property (@(posedge clk) disable iff (rst)
    hold_lp |-> !core_rst);

endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq
  import rcs_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int DLY_CYC       = 4,
  parameter int PULSE_LEN     = 16,
  parameter int HOLD_ON_PFAIL = 1
) (
  input  logic               clk,
  input  logic               cold_rst,
  input  logic               man_req_n,
  input  logic               pfail_n,
  input  logic               wdog_n,
  input  logic               fetch_err_n,
  input  logic               bus_we,
  input  logic               bus_addr,
  input  logic [CAUSE_W-1:0] bus_wdata,
  output logic [CAUSE_W-1:0] cause_flags,
  output logic               power_on,
  output logic               core_rst,
  output logic               hold_lp
);

  logic [N_REQ-1:0]  raw_n;
  logic [N_REQ-1:0]  sync_n;
  logic              fire;
  logic [HW_W-1:0]   cause_oh;
  logic              any_req;
  logic              busy;
  logic              sw_hs;
  logic              sw_sw;
  logic              clr_wr;
  logic [FLAG_W-1:0] clr_mask;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] cause_q;
  logic              seq_start;
  logic              unused_hi;

  always_comb begin
    raw_n        = '1;
    raw_n[L_MAN] = man_req_n;
    raw_n[L_PF]  = pfail_n;
    raw_n[L_WD]  = wdog_n;
    raw_n[L_IF]  = fetch_err_n;
  end

  rcs_sync #(
    .WIDTH  (N_REQ),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (cold_rst),
    .din  (raw_n),
    .dout (sync_n)
  );

  rcs_decode u_decode (
    .clk      (clk),
    .rst      (cold_rst),
    .lines_n  (sync_n),
    .armed    (~busy),
    .fire     (fire),
    .cause_oh (cause_oh),
    .any_req  (any_req)
  );

  // Register bus decode
  assign sw_hs    = bus_we & bus_addr & bus_wdata[B_HS] & ~cold_rst;
  assign sw_sw    = bus_we & bus_addr & bus_wdata[B_SW] & ~cold_rst;
  assign clr_wr   = bus_we & ~bus_addr;
  assign clr_mask = clr_wr ? bus_wdata[FLAG_W-1:0] : '0;
  assign unused_hi = &{1'b0, bus_wdata[CAUSE_W-1:FLAG_W]};

  assign set_vec = {(fire ? cause_oh : {HW_W{1'b0}}), sw_hs, sw_sw};

  // Sticky flags: set beats clear, only cold reset wipes them
  always_ff @(posedge clk) begin
    if (cold_rst) cause_q <= '0;
    else          cause_q <= (cause_q & ~clr_mask) | set_vec;
  end

  assign cause_flags = {{(CAUSE_W-FLAG_W){1'b0}}, cause_q};
  assign power_on    = ~|cause_q;

  assign seq_start = fire | (sw_hs & ~busy);

  rcs_seq #(
    .DLY_CYC       (DLY_CYC),
    .PULSE_LEN     (PULSE_LEN),
    .HOLD_ON_PFAIL (HOLD_ON_PFAIL)
  ) u_seq (
    .clk        (clk),
    .rst        (cold_rst),
    .start      (seq_start),
    .start_hold (fire & cause_oh[2]),
    .pf_ok      (sync_n[L_PF]),
    .req_active (any_req),
    .core_rst   (core_rst),
    .hold_lp    (hold_lp),
    .busy       (busy)
  );

  // R10: anything being set is present on the next cycle, clear or not
  p_set_wins_r10: assert property (@(posedge clk) disable iff (cold_rst)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  // R9: during a running sequence the hardware flags only change by a clear
  p_busy_hw_stable_r9: assert property (@(posedge clk) disable iff (cold_rst)
    (busy && !clr_wr) |=> $stable(cause_q[B_MAN:B_IA]));

endmodule

// File: tb/test_rst_cause_seq.sv
`timescale 1ns/1ps
module test_rst_cause_seq;

  localparam int DLY = 3;
  localparam int PL  = 16;

  logic       clk = 1'b0;
  logic       cold_rst;
  logic       man_req_n, pfail_n, wdog_n, fetch_err_n;
  logic       bus_we, bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] cause_flags;
  logic       power_on, core_rst, hold_lp;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_c;

  always #2.5 clk = ~clk;

  rst_cause_seq #(
    .SYNC_STAGES   (2),
    .DLY_CYC       (DLY),
    .PULSE_LEN     (PL),
    .HOLD_ON_PFAIL (1)
  ) i_rst_cause_seq (
    .clk         (clk),
    .cold_rst    (cold_rst),
    .man_req_n   (man_req_n),
    .pfail_n     (pfail_n),
    .wdog_n      (wdog_n),
    .fetch_err_n (fetch_err_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cause_flags (cause_flags),
    .power_on    (power_on),
    .core_rst    (core_rst),
    .hold_lp     (hold_lp)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // low mask: bit0 manual, bit1 power-fail, bit2 watchdog, bit3 fetch
  task automatic set_lines(logic [3:0] low);
    man_req_n   = ~low[0];
    pfail_n     = ~low[1];
    wdog_n      = ~low[2];
    fetch_err_n = ~low[3];
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_we = 1'b0; bus_wdata = 8'h00;
  endtask

  function automatic logic [7:0] hw_bit(logic [3:0] low);
    if (low[0])      return 8'h20;
    else if (low[1]) return 8'h10;
    else if (low[2]) return 8'h08;
    else             return 8'h04;
  endfunction

  task automatic wait_done();
    int g = 0;
    while (!core_rst && g < 200) begin tick(1); g++; end
    while (core_rst && g < 400) begin tick(1); g++; end
    tick(3);
  endtask

  task automatic measure_pulse(string req);
    int g = 0;
    int n = 0;
    while (!core_rst && g < 100) begin tick(1); g++; end
    while (core_rst && n < 1000) begin tick(1); n++; end
    chk8(req, 8'(n), 8'(PL));
    tick(3);
  endtask

  initial begin
    tick(100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog (all): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    cold_rst = 1'b1;
    set_lines(4'b0000);
    bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    tick(3);
    cold_rst = 1'b0;
    tick(1);
    // Reset state
    chk8("R1 reset flags", cause_flags, 8'h00);
    chk1("R11 reset power_on", power_on, 1'b1);
    chk1("R1 reset core_rst", core_rst, 1'b0);
    chk1("R12 reset hold", hold_lp, 1'b0);

    // Manual event: latency, delay, exact pulse
    set_lines(4'b0001);
    tick(2);
    chk8("R4 not yet", cause_flags, 8'h00);
    tick(1);
    chk8("R4 manual flag", cause_flags, 8'h20);
    chk1("R11 flag set", power_on, 1'b0);
    tick(2);
    set_lines(4'b0000);
    chk1("R6 before delay", core_rst, 1'b0);
    tick(1);
    chk1("R6 rise", core_rst, 1'b1);
    tick(PL - 1);
    chk1("R7 still high", core_rst, 1'b1);
    tick(1);
    chk1("R7 fall", core_rst, 1'b0);
    tick(3);

    // Watchdog held long: stretched pulse, sticky accumulation
    set_lines(4'b0100);
    tick(22);
    chk1("R7 extended", core_rst, 1'b1);
    chk8("R8 sticky", cause_flags, 8'h28);
    set_lines(4'b0000);
    tick(2);
    chk1("R7 ext before release", core_rst, 1'b1);
    tick(1);
    chk1("R7 ext release", core_rst, 1'b0);
    tick(3);

    // Clear and priority
    bus_write(1'b0, 8'hFF);
    chk8("R10 clear all", cause_flags, 8'h00);
    chk1("R11 cleared", power_on, 1'b1);
    set_lines(4'b0111);
    tick(3);
    chk8("R2 manual wins", cause_flags, 8'h20);
    tick(2);
    set_lines(4'b0000);
    wait_done();
    bus_write(1'b0, 8'h20);
    set_lines(4'b0110);
    tick(3);
    chk8("R2 pfail over wdog", cause_flags, 8'h10);
    chk1("R12 hold entered", hold_lp, 1'b1);
    tick(10);
    chk1("R12 reset withheld", core_rst, 1'b0);
    set_lines(4'b0000);
    tick(2);
    chk1("R12 still holding", hold_lp, 1'b1);
    tick(1);
    chk1("R12 hold left", hold_lp, 1'b0);
    tick(DLY - 1);
    chk1("R12 delay", core_rst, 1'b0);
    tick(1);
    chk1("R12 rise", core_rst, 1'b1);
    tick(PL - 1);
    chk1("R7 hold pulse high", core_rst, 1'b1);
    tick(1);
    chk1("R7 hold pulse end", core_rst, 1'b0);
    tick(3);

    // One-cycle illegal-fetch strobe
    bus_write(1'b0, 8'hFF);
    set_lines(4'b1000);
    tick(1);
    set_lines(4'b0000);
    tick(2);
    chk8("R3 fetch flag", cause_flags, 8'h04);
    tick(3);
    chk1("R6 fetch rise", core_rst, 1'b1);
    tick(PL - 1);
    chk1("R7 min width", core_rst, 1'b1);
    tick(1);
    chk1("R7 min end", core_rst, 1'b0);
    tick(3);

    // Request during running sequence is ignored
    bus_write(1'b0, 8'hFF);
    set_lines(4'b0100);
    tick(2);
    set_lines(4'b0000);
    tick(5);
    set_lines(4'b0001);
    tick(2);
    set_lines(4'b0000);
    wait_done();
    chk8("R9 no second flag", cause_flags, 8'h08);
    chk1("R9 no second pulse", core_rst, 1'b0);

    // Software requests
    bus_write(1'b0, 8'hFF);
    bus_write(1'b1, 8'hC0);
    chk8("R1 upper bits zero", cause_flags, 8'h00);
    bus_write(1'b1, 8'h01);
    chk8("R5 sw flag", cause_flags, 8'h01);
    tick(DLY + 6);
    chk1("R5 sw no reset", core_rst, 1'b0);
    bus_write(1'b1, 8'h02);
    chk8("R5 hs flag", cause_flags, 8'h03);
    tick(DLY - 1);
    chk1("R6 hs before", core_rst, 1'b0);
    tick(1);
    chk1("R6 hs rise", core_rst, 1'b1);
    wait_done();

    // Set beats clear on the same edge
    bus_write(1'b0, 8'hFF);
    bus_write(1'b1, 8'h01);
    set_lines(4'b0001);
    tick(2);
    bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h21;
    tick(1);
    bus_we = 1'b0; bus_wdata = 8'h00;
    chk8("R10 set wins", cause_flags, 8'h20);
    set_lines(4'b0000);
    wait_done();

    // Cold reset clears
    chk8("R8 survives core reset", cause_flags, 8'h20);
    cold_rst = 1'b1;
    tick(2);
    cold_rst = 1'b0;
    tick(1);
    chk8("R8 cold clears", cause_flags, 8'h00);
    chk1("R11 cold power_on", power_on, 1'b1);

    // Random events against the model
    exp_c = 8'h00;
    for (int it = 0; it < 30; it++) begin
      logic [3:0] msk;
      logic [7:0] cm;
      msk = 4'($urandom_range(1, 15));
      cm  = 8'($urandom) & 8'h3F;
      bus_write(1'b0, cm);
      exp_c = exp_c & ~cm;
      chk8("R10 random clear", cause_flags, exp_c);
      if ($urandom_range(0, 3) == 0) begin
        bus_write(1'b1, 8'h01);
        exp_c = exp_c | 8'h01;
      end
      set_lines(msk);
      tick(3);
      exp_c = exp_c | hw_bit(msk);
      chk8("R2 random decode", cause_flags, exp_c);
      chk1("R12 random hold", hold_lp, msk[1] & ~msk[0]);
      tick(1);
      set_lines(4'b0000);
      measure_pulse("R7 random width");
    end

    summary();
    $finish;
  end

endmodule